// File: doc/BRIEF.md
# Dual-Thread Branch Prediction Queue

This block is the run-ahead part of an instruction front end shared by two hardware threads. A single prediction engine serves both threads. Each cycle it picks one thread, takes that thread's current fetch pointer and writes it into the thread's own queue. It then works out the thread's next fetch pointer. Fetch drains each queue at its own pace. Prediction for a thread pauses only while that thread's queue is full, so the other thread keeps the engine.

The next pointer comes from two sources. A table of 2-bit saturating counters decides whether the pointer is a taken branch. Only for a taken prediction is a target searched, first in a small set-associative target buffer and then in a larger, slower one. A first-level hit idles the thread for one extra cycle. Going to the second level idles it for several cycles. Both threads compete for the same counter and buffer entries. Resolved branches arrive on an update port. They train the counters and install targets in the first level, and an entry displaced there moves down to the second level. A redirect restarts one thread at a new pointer and discards only that thread's queued pointers.

Top module: `twin_thread_predq`

## Requirements
- R1: After reset both queues are empty (`headValid` = 0), and a thread produces no pointers until it has received a redirect.
- R2: A redirect for thread t empties only queue t at that clock edge; the other queue keeps its contents. The redirect pointer is written into queue t at the following edge, so it shows at the head one cycle after the queue went empty.
- R3: Each queue is a FIFO of QDEPTH (default 8) pointers delivered in production order. A thread whose queue holds QDEPTH entries is not predicted, and it resumes once fetch pops.
- R4: When both threads are eligible, the engine alternates between them each cycle. A thread is eligible when it has been redirected, is not idling after a lookup and has a queue that is not full. A thread alone is served every cycle it is eligible.
- R5: Direction comes from 2-bit counters indexed by the low DIR_BITS bits of the pointer. Counters reset to 01, and a value of 10 or 11 means taken. A resolved branch increments the counter (taken) or decrements it (not taken), saturating at 11 and 00.
- R6: A pointer predicted not taken is followed by pointer+1 in the next cycle the thread is served, with no idle cycle.
- R7: A taken prediction that hits the first-level buffer is followed by the stored target. The thread then idles one cycle, so the two pointers appear two cycles apart.
- R8: A taken prediction that misses the first level is followed by the second-level target on a hit, or by pointer+1 on a miss in both levels. In either case the thread idles L2_PEN cycles (default 3), so the two pointers appear four cycles apart.
- R9: A taken resolved branch installs its target in the first level, or overwrites the target if the pointer is already present there. A not-taken resolved branch only moves its counter.
- R10: A first-level install uses the lowest invalid way of its set. If the set is full, it replaces ways in round-robin order starting at way 0, and the displaced entry is written into the second level.
- R11: Counters and buffer entries are shared by both threads, so training by any branch is seen by whichever thread next predicts that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| redirValid | input | 2 | Per-thread redirect strobe |
| redirPtr | input | 2 x PTR_W | Per-thread restart pointer |
| updValid | input | 1 | Resolved-branch update strobe |
| updPtr | input | PTR_W | Pointer of the resolved branch |
| updTaken | input | 1 | Resolved direction |
| updTarget | input | PTR_W | Resolved target |
| popReq | input | 2 | Per-thread pop from fetch; ignored on an empty queue |
| headPtr | output | 2 x PTR_W | Oldest queued pointer per thread |
| headValid | output | 2 | Queue not empty per thread |

## Verification
The assertions assume the control never offers a push to a full queue. They also assume that a redirect lands on a queue in the cycle before its restart pointer, and that a first-level hit keeps its thread out of the next cycle. None of these depends on fetch behaviour, since pops on an empty queue are dropped. The stimulus trains the predictor only while both queues are full, so no lookup races an update. During each observed stream it pops every cycle, so the spacing of head pointers equals the engine's production spacing. Between streams it lets both queues refill, so that only the thread under test competes for the engine.

// File: rtl/predq_pkg.sv
package predq_pkg;

  typedef enum logic [1:0] {
    LK_SEQ,
    LK_L1,
    LK_L2,
    LK_MISS
  } lookKind_e;

  typedef struct packed {
    logic [1:0] push;
    logic [1:0] flush;
    logic       gntValid;
    logic       gntThread;
  } predqStrobe_t;

endpackage

// File: rtl/predq_queue.sv
module predq_queue #(
  parameter int PTR_W  = 16,
  parameter int QDEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [PTR_W-1:0] pushData,
  input  logic             pop,
  input  logic             flush,
  output logic             full,
  output logic             headValid,
  output logic [PTR_W-1:0] headData
);
  localparam int AW = $clog2(QDEPTH);
  localparam int CW = $clog2(QDEPTH + 1);

  logic [PTR_W-1:0] mem [QDEPTH];
  logic [AW-1:0]    wrP, rdP;
  logic [CW-1:0]    cnt;
  logic             doPush, doPop;

  assign full      = (cnt == CW'(QDEPTH));
  assign headValid = (cnt != '0);
  assign headData  = mem[rdP];
  assign doPush    = push && !full;
  assign doPop     = pop && headValid;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrP <= '0;
      rdP <= '0;
      cnt <= '0;
    end else begin
      if (doPush) wrP <= (wrP == AW'(QDEPTH - 1)) ? '0 : wrP + 1'b1;
      if (doPop)  rdP <= (rdP == AW'(QDEPTH - 1)) ? '0 : rdP + 1'b1;
      if (doPush && !doPop)      cnt <= cnt + 1'b1;
      else if (!doPush && doPop) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrP] <= pushData;
  end

  // R3: control never offers a pointer to a full queue
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (cnt < CW'(QDEPTH)));

  // R2: a flush leaves the queue empty
  a_r2_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (cnt == '0));

endmodule

// File: rtl/predq_ctrl.sv
module predq_ctrl
  import predq_pkg::*;
#(
  parameter int L1_PEN = 1,
  parameter int L2_PEN = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   redirValid,
  input  logic [1:0]   qFull,
  input  lookKind_e    lookKind,
  output predqStrobe_t strb
);
  localparam int MAXP = (L2_PEN > L1_PEN) ? L2_PEN : L1_PEN;
  localparam int SW   = $clog2(MAXP + 1);

  logic [1:0]    active;
  logic [SW-1:0] stall [2];
  logic          lastGnt;
  logic [1:0]    elig;
  logic [SW-1:0] pen;

  always_comb begin
    for (int t = 0; t < 2; t++)
      elig[t] = active[t] && (stall[t] == '0) && !qFull[t] && !redirValid[t];
    strb.gntValid  = |elig;
    if (&elig)        strb.gntThread = ~lastGnt;
    else if (elig[0]) strb.gntThread = 1'b0;
    else              strb.gntThread = 1'b1;
    strb.push[0] = strb.gntValid && !strb.gntThread;
    strb.push[1] = strb.gntValid &&  strb.gntThread;
    strb.flush   = redirValid;
  end

  always_comb begin
    case (lookKind)
      LK_L1:         pen = SW'(L1_PEN);
      LK_L2, LK_MISS: pen = SW'(L2_PEN);
      default:       pen = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= '0;
      lastGnt <= 1'b1;
      for (int t = 0; t < 2; t++) stall[t] <= '0;
    end else begin
      if (strb.gntValid) lastGnt <= strb.gntThread;
      for (int t = 0; t < 2; t++) begin
        if (redirValid[t]) begin
          active[t] <= 1'b1;
          stall[t]  <= '0;
        end else if (strb.push[t]) begin
          stall[t] <= pen;
        end else if (stall[t] != '0) begin
          stall[t] <= stall[t] - 1'b1;
        end
      end
    end
  end

  // R4: at most one thread is served per cycle
  a_r4_single_push: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.push));

  // R7: a first-level hit keeps its thread out of the following cycle
  a_r7_bubble_t0: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push[0] && lookKind == LK_L1) |=> !strb.push[0]);
  a_r7_bubble_t1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push[1] && lookKind == LK_L1) |=> !strb.push[1]);

endmodule

// File: rtl/predq_datapath.sv
module predq_datapath
  import predq_pkg::*;
#(
  parameter int PTR_W    = 16,
  parameter int DIR_BITS = 6,
  parameter int L1_SETS  = 16,
  parameter int L1_WAYS  = 4,
  parameter int L2_SETS  = 32,
  parameter int L2_WAYS  = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  predqStrobe_t          strb,
  input  logic [1:0][PTR_W-1:0] redirPtr,
  input  logic                  updValid,
  input  logic [PTR_W-1:0]      updPtr,
  input  logic                  updTaken,
  input  logic [PTR_W-1:0]      updTarget,
  output logic [PTR_W-1:0]      pushPtr,
  output lookKind_e             lookKind
);
  localparam int DIR_N = 1 << DIR_BITS;
  localparam int L1_SB = $clog2(L1_SETS);
  localparam int L1_TW = PTR_W - L1_SB;
  localparam int L1_WB = $clog2(L1_WAYS);
  localparam int L2_SB = $clog2(L2_SETS);
  localparam int L2_TW = PTR_W - L2_SB;
  localparam int L2_WB = $clog2(L2_WAYS);

  logic [PTR_W-1:0] pc [2];
  logic [1:0]       dirTab [DIR_N];

  logic             l1Val [L1_SETS][L1_WAYS];
  logic [L1_TW-1:0] l1Tag [L1_SETS][L1_WAYS];
  logic [PTR_W-1:0] l1Tgt [L1_SETS][L1_WAYS];
  logic [L1_WB-1:0] l1Rr  [L1_SETS];
  logic             l2Val [L2_SETS][L2_WAYS];
  logic [L2_TW-1:0] l2Tag [L2_SETS][L2_WAYS];
  logic [PTR_W-1:0] l2Tgt [L2_SETS][L2_WAYS];
  logic [L2_WB-1:0] l2Rr  [L2_SETS];

  // lookup for the served thread
  logic [PTR_W-1:0] cur, nextPtr, l1HitTgt, l2HitTgt;
  logic [L1_SB-1:0] cSet1;
  logic [L2_SB-1:0] cSet2;
  logic             taken, l1Hit, l2Hit;

  always_comb begin
    cur      = pc[strb.gntThread];
    taken    = dirTab[cur[DIR_BITS-1:0]][1];
    cSet1    = cur[L1_SB-1:0];
    cSet2    = cur[L2_SB-1:0];
    l1Hit    = 1'b0;
    l2Hit    = 1'b0;
    l1HitTgt = '0;
    l2HitTgt = '0;
    for (int w = 0; w < L1_WAYS; w++)
      if (l1Val[cSet1][w] && l1Tag[cSet1][w] == cur[PTR_W-1:L1_SB]) begin
        l1Hit    = 1'b1;
        l1HitTgt = l1Tgt[cSet1][w];
      end
    for (int w = 0; w < L2_WAYS; w++)
      if (l2Val[cSet2][w] && l2Tag[cSet2][w] == cur[PTR_W-1:L2_SB]) begin
        l2Hit    = 1'b1;
        l2HitTgt = l2Tgt[cSet2][w];
      end
    if (!strb.gntValid || !taken) begin
      lookKind = LK_SEQ;
      nextPtr  = cur + 1'b1;
    end else if (l1Hit) begin
      lookKind = LK_L1;
      nextPtr  = l1HitTgt;
    end else if (l2Hit) begin
      lookKind = LK_L2;
      nextPtr  = l2HitTgt;
    end else begin
      lookKind = LK_MISS;
      nextPtr  = cur + 1'b1;
    end
    pushPtr = cur;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < 2; t++) pc[t] <= '0;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (strb.flush[t])     pc[t] <= redirPtr[t];
        else if (strb.push[t]) pc[t] <= nextPtr;
      end
    end
  end

  // update side: first-level placement and spill to second level
  logic [DIR_BITS-1:0] uIdx;
  logic [L1_SB-1:0]    uSet1;
  logic [L1_TW-1:0]    uTag1;
  logic                uHit1, uFree1, doInstall, doEvict;
  logic [L1_WB-1:0]    uHitWay1, uFreeWay1, vWay1;
  logic [PTR_W-1:0]    vPtr, vTgt;
  logic [L2_SB-1:0]    vSet2;
  logic [L2_TW-1:0]    vTag2;
  logic                vHit2, vFree2;
  logic [L2_WB-1:0]    vHitWay2, vFreeWay2, vWay2;

  always_comb begin
    uIdx      = updPtr[DIR_BITS-1:0];
    uSet1     = updPtr[L1_SB-1:0];
    uTag1     = updPtr[PTR_W-1:L1_SB];
    uHit1     = 1'b0;
    uFree1    = 1'b0;
    uHitWay1  = '0;
    uFreeWay1 = '0;
    for (int w = 0; w < L1_WAYS; w++) begin
      if (l1Val[uSet1][w] && l1Tag[uSet1][w] == uTag1 && !uHit1) begin
        uHit1    = 1'b1;
        uHitWay1 = L1_WB'(w);
      end
      if (!l1Val[uSet1][w] && !uFree1) begin
        uFree1    = 1'b1;
        uFreeWay1 = L1_WB'(w);
      end
    end
    vWay1     = uHit1 ? uHitWay1 : (uFree1 ? uFreeWay1 : l1Rr[uSet1]);
    doInstall = updValid && updTaken;
    doEvict   = doInstall && !uHit1 && !uFree1;
    vPtr      = {l1Tag[uSet1][vWay1], uSet1};
    vTgt      = l1Tgt[uSet1][vWay1];
    vSet2     = vPtr[L2_SB-1:0];
    vTag2     = vPtr[PTR_W-1:L2_SB];
    vHit2     = 1'b0;
    vFree2    = 1'b0;
    vHitWay2  = '0;
    vFreeWay2 = '0;
    for (int w = 0; w < L2_WAYS; w++) begin
      if (l2Val[vSet2][w] && l2Tag[vSet2][w] == vTag2 && !vHit2) begin
        vHit2    = 1'b1;
        vHitWay2 = L2_WB'(w);
      end
      if (!l2Val[vSet2][w] && !vFree2) begin
        vFree2    = 1'b1;
        vFreeWay2 = L2_WB'(w);
      end
    end
    vWay2 = vHit2 ? vHitWay2 : (vFree2 ? vFreeWay2 : l2Rr[vSet2]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DIR_N; i++) dirTab[i] <= 2'b01;
    end else if (updValid) begin
      if (updTaken && dirTab[uIdx] != 2'b11)       dirTab[uIdx] <= dirTab[uIdx] + 1'b1;
      else if (!updTaken && dirTab[uIdx] != 2'b00) dirTab[uIdx] <= dirTab[uIdx] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < L1_SETS; s++) begin
        l1Rr[s] <= '0;
        for (int w = 0; w < L1_WAYS; w++) l1Val[s][w] <= 1'b0;
      end
      for (int s = 0; s < L2_SETS; s++) begin
        l2Rr[s] <= '0;
        for (int w = 0; w < L2_WAYS; w++) l2Val[s][w] <= 1'b0;
      end
    end else begin
      if (doInstall) begin
        l1Val[uSet1][vWay1] <= 1'b1;
        if (!uHit1 && !uFree1)
          l1Rr[uSet1] <= (l1Rr[uSet1] == L1_WB'(L1_WAYS - 1)) ? '0 : l1Rr[uSet1] + 1'b1;
      end
      if (doEvict) begin
        l2Val[vSet2][vWay2] <= 1'b1;
        if (!vHit2 && !vFree2)
          l2Rr[vSet2] <= (l2Rr[vSet2] == L2_WB'(L2_WAYS - 1)) ? '0 : l2Rr[vSet2] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doInstall) begin
      l1Tag[uSet1][vWay1] <= uTag1;
      l1Tgt[uSet1][vWay1] <= updTarget;
    end
    if (doEvict) begin
      l2Tag[vSet2][vWay2] <= vTag2;
      l2Tgt[vSet2][vWay2] <= vTgt;
    end
  end

endmodule

// File: rtl/twin_thread_predq.sv
module twin_thread_predq
  import predq_pkg::*;
#(
  parameter int PTR_W    = 16,
  parameter int DIR_BITS = 6,
  parameter int L1_SETS  = 16,
  parameter int L1_WAYS  = 4,
  parameter int L2_SETS  = 32,
  parameter int L2_WAYS  = 5,
  parameter int L1_PEN   = 1,
  parameter int L2_PEN   = 3,
  parameter int QDEPTH   = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            redirValid,
  input  logic [1:0][PTR_W-1:0] redirPtr,
  input  logic                  updValid,
  input  logic [PTR_W-1:0]      updPtr,
  input  logic                  updTaken,
  input  logic [PTR_W-1:0]      updTarget,
  input  logic [1:0]            popReq,
  output logic [1:0][PTR_W-1:0] headPtr,
  output logic [1:0]            headValid
);
  predqStrobe_t     strb;
  lookKind_e        lookKind;
  logic [PTR_W-1:0] pushPtr;
  logic [1:0]       qFull;

  predq_ctrl #(.L1_PEN(L1_PEN), .L2_PEN(L2_PEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .redirValid (redirValid),
    .qFull      (qFull),
    .lookKind   (lookKind),
    .strb       (strb)
  );

  predq_datapath #(
    .PTR_W(PTR_W), .DIR_BITS(DIR_BITS), .L1_SETS(L1_SETS), .L1_WAYS(L1_WAYS),
    .L2_SETS(L2_SETS), .L2_WAYS(L2_WAYS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .redirPtr  (redirPtr),
    .updValid  (updValid),
    .updPtr    (updPtr),
    .updTaken  (updTaken),
    .updTarget (updTarget),
    .pushPtr   (pushPtr),
    .lookKind  (lookKind)
  );

  for (genvar t = 0; t < 2; t++) begin : g_q
    predq_queue #(.PTR_W(PTR_W), .QDEPTH(QDEPTH)) u_q (
      .clk       (clk),
      .rstN      (rstN),
      .push      (strb.push[t]),
      .pushData  (pushPtr),
      .pop       (popReq[t]),
      .flush     (strb.flush[t]),
      .full      (qFull[t]),
      .headValid (headValid[t]),
      .headData  (headPtr[t])
    );

    // R2: the cycle after a redirect the thread's queue shows nothing
    a_r2_redir_clears: assert property (@(posedge clk) disable iff (!rstN)
      redirValid[t] |=> !headValid[t]);
  end

endmodule

// File: tb/twin_thread_predq_tb.sv
module twin_thread_predq_tb;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       redirValid;
  logic [1:0][15:0] redirPtr;
  logic             updValid;
  logic [15:0]      updPtr;
  logic             updTaken;
  logic [15:0]      updTarget;
  logic [1:0]       popReq;
  logic [1:0][15:0] headPtr;
  logic [1:0]       headValid;

  twin_thread_predq u_dut (
    .clk(clk), .rstN(rstN), .redirValid(redirValid), .redirPtr(redirPtr),
    .updValid(updValid), .updPtr(updPtr), .updTaken(updTaken), .updTarget(updTarget),
    .popReq(popReq), .headPtr(headPtr), .headValid(headValid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [15:0] rec  [2][64];
  int          rcyc [2][64];
  int          rn   [2];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic redirect(input int t, input logic [15:0] p);
    @(negedge clk); redirValid[t] = 1'b1; redirPtr[t] = p;
    @(negedge clk); redirValid[t] = 1'b0;
  endtask

  task automatic train(input logic [15:0] p, input logic tk, input logic [15:0] tg);
    @(negedge clk); updValid = 1'b1; updPtr = p; updTaken = tk; updTarget = tg;
    @(negedge clk); updValid = 1'b0;
  endtask

  task automatic watch(input int n, input logic [1:0] mask);
    rn[0] = 0; rn[1] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int t = 0; t < 2; t++) begin
        if (mask[t] && headValid[t] && rn[t] < 64) begin
          rec[t][rn[t]]  = headPtr[t];
          rcyc[t][rn[t]] = cyc;
          rn[t]++;
          popReq[t] = 1'b1;
        end else popReq[t] = 1'b0;
      end
    end
    @(negedge clk); popReq = 2'b00;
  endtask

  task automatic expectSeq(input int t, input int k, input logic [15:0] p,
                           input int gap, input string req);
    chk(rn[t] > k, req, rn[t], k + 1);
    if (rn[t] > k) begin
      chk(rec[t][k] == p, req, int'(rec[t][k]), int'(p));
      if (gap > 0)
        chk(rcyc[t][k] - rcyc[t][k-1] == gap, req, rcyc[t][k] - rcyc[t][k-1], gap);
    end
  endtask

  // single-thread stream from a redirect; other queue assumed full
  task automatic stream(input int t, input logic [15:0] p);
    redirect(t, p);
    watch(12, (t == 0) ? 2'b01 : 2'b10);
  endtask

  logic [15:0] hold;

  initial begin
    rstN = 1'b0; redirValid = '0; redirPtr = '0; updValid = 1'b0; updPtr = '0;
    updTaken = 1'b0; updTarget = '0; popReq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: empty after reset and idle without a redirect
    chk(headValid == 2'b00, "R1 reset empty", headValid, 0);
    settle(20);
    chk(headValid == 2'b00, "R1 idle until redirect", headValid, 0);

    // R3: fill to depth, head holds, order preserved while draining
    redirect(0, 16'h0100);
    settle(30);
    chk(headValid[0] && headPtr[0] == 16'h0100, "R3 head held while full", headPtr[0], 16'h0100);
    watch(12, 2'b01);
    for (int k = 0; k < 12; k++) expectSeq(0, k, 16'h0100 + 16'(k), 0, "R3/R6 fifo order");
    chk(!headValid[1], "R1 thread1 still idle", headValid[1], 0);

    // R2: flush of one thread leaves the other alone
    redirect(1, 16'h0780);
    settle(60);
    @(negedge clk); hold = headPtr[1]; redirValid[0] = 1'b1; redirPtr[0] = 16'h0900;
    @(negedge clk); redirValid[0] = 1'b0;
    chk(!headValid[0], "R2 flushed queue empty", headValid[0], 0);
    chk(headValid[1] && headPtr[1] == hold, "R2 other queue kept", headPtr[1], hold);
    @(negedge clk);
    chk(headValid[0] && headPtr[0] == 16'h0900, "R2 restart pointer", headPtr[0], 16'h0900);
    settle(60);

    // R4: both threads eligible alternate
    @(negedge clk); redirValid = 2'b11; redirPtr[0] = 16'h0A00; redirPtr[1] = 16'h0B00;
    @(negedge clk); redirValid = 2'b00;
    watch(16, 2'b11);
    for (int k = 0; k < 6; k++) begin
      expectSeq(0, k, 16'h0A00 + 16'(k), (k > 0) ? 2 : 0, "R4 thread0 alternate");
      expectSeq(1, k, 16'h0B00 + 16'(k), (k > 0) ? 2 : 0, "R4 thread1 alternate");
    end
    chk((rcyc[0][0] - rcyc[1][0] == 1) || (rcyc[1][0] - rcyc[0][0] == 1),
        "R4 interleave", rcyc[0][0] - rcyc[1][0], 1);
    settle(60);

    // R5/R7/R9/R11: train a taken branch, both threads follow it
    train(16'h020A, 1'b1, 16'h0300);
    train(16'h020A, 1'b1, 16'h0300);
    stream(1, 16'h0208);
    expectSeq(1, 0, 16'h0208, 0, "R7 stream start");
    expectSeq(1, 1, 16'h0209, 1, "R6 sequential");
    expectSeq(1, 2, 16'h020A, 1, "R6 sequential");
    expectSeq(1, 3, 16'h0300, 2, "R7 first-level hit target");
    expectSeq(1, 4, 16'h0301, 1, "R6 after target");
    settle(60);
    stream(0, 16'h0209);
    expectSeq(0, 2, 16'h0300, 2, "R11 shared entry other thread");
    settle(60);

    // R5: saturating counter 11 -> 10 still taken, -> 01 not taken
    train(16'h020A, 1'b0, 16'h0000);
    stream(0, 16'h020A);
    expectSeq(0, 1, 16'h0300, 2, "R5 counter 10 taken");
    settle(60);
    train(16'h020A, 1'b0, 16'h0000);
    stream(1, 16'h020A);
    expectSeq(1, 1, 16'h020B, 1, "R5 counter 01 not taken");
    settle(60);
    // R9: taken update overwrites the stored target
    train(16'h020A, 1'b1, 16'h0340);
    stream(0, 16'h020A);
    expectSeq(0, 1, 16'h0340, 2, "R9 target overwrite");
    settle(60);

    // R10/R8: five branches on one first-level set
    for (int i = 0; i < 5; i++) begin
      train(16'h0405 + 16'(i * 16), 1'b1, 16'h0600 + 16'(i * 16));
      train(16'h0405 + 16'(i * 16), 1'b1, 16'h0600 + 16'(i * 16));
    end
    stream(0, 16'h0404);
    expectSeq(0, 1, 16'h0405, 1, "R6 before spilled branch");
    expectSeq(0, 2, 16'h0600, 4, "R8 second-level hit");
    expectSeq(0, 3, 16'h0601, 1, "R6 after second-level target");
    settle(60);
    stream(1, 16'h0445);
    expectSeq(1, 1, 16'h0640, 2, "R10 newest in first level");
    settle(60);
    stream(0, 16'h0415);
    expectSeq(0, 1, 16'h0610, 2, "R10 way1 still first level");
    settle(60);
    train(16'h0455, 1'b1, 16'h0650);
    train(16'h0455, 1'b1, 16'h0650);
    stream(1, 16'h0415);
    expectSeq(1, 1, 16'h0610, 4, "R10 round-robin spill of way1");
    settle(60);
    stream(0, 16'h0425);
    expectSeq(0, 1, 16'h0620, 2, "R10 way2 untouched");
    settle(60);
    stream(1, 16'h0455);
    expectSeq(1, 1, 16'h0650, 2, "R9 install on taken");
    settle(60);
    stream(0, 16'h0045);
    expectSeq(0, 1, 16'h0046, 4, "R8 miss both levels");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule